// File: doc/BRIEF.md
# Three-Wire Control Byte Receiver

This block is a write-only slave for a three-wire serial control bus made of a clock line, a data line and a mode line. While the mode line is low the incoming byte is an address. While it is high the incoming bytes are data. Bits arrive least significant first, one per rising edge of the bus clock, in groups of eight. The three lines are brought into the system clock domain through synchronisers, and the bus clock is sampled as a level, so the bus runs well below the system clock.

An address byte names a device and picks one of two register sets. The set in force chooses which codec control fields a data byte may load. The DATA set holds volume, de-emphasis, mute and the ADC/DAC power enables. The STATUS set holds the sample-clock ratio, the serial audio format and the DC-filter enable. The decoded fields drive the audio datapath directly as plain level outputs.

Top module: `ctl3w_rx`

## Requirements
- R1: Each byte is taken least significant bit first, one bit per rising edge of `cbus_clk_i`. A byte is acted on only once its eighth bit has arrived, and each completed byte is acted on exactly once.
- R2: A completed byte received with `cbus_mode_i` low is an address. It selects the device when its bits 7:2 equal 6'b000101. Its bits 1:0 then pick the set: 00 picks DATA, 10 picks STATUS, and 01 or 11 pick no set, so later data bytes are dropped. An address byte never changes any control field.
- R3: An address whose bits 7:2 differ from 000101 clears `dev_sel_o`. Every data byte after it is ignored until a matching address arrives.
- R4: The device selection and the chosen set persist over any number of data bytes. Only a new address byte changes them.
- R5: A level change on `cbus_mode_i` discards any partly received byte and restarts the bit count. A partial byte changes no field.
- R6: In the DATA set, a byte with bits 7:6 = 00 loads `vol_code_o` from bits 5:0.
- R7: In the DATA set, a byte with bits 7:6 = 10 loads `deemph_o` from bits 4:3 and `mute_o` from bit 2. A byte with bits 7:6 = 01 changes nothing.
- R8: In the DATA set, a byte with bits 7:6 = 11 loads `adc_en_o` from bit 1 and `dac_en_o` from bit 0.
- R9: In the STATUS set, a byte with bits 7:6 = 00 loads `clk_rate_o` from bits 5:4 (00 = 512, 01 = 384, 10 = 256 times the sample rate), `in_fmt_o` from bits 3:1 and `dc_filt_en_o` from bit 0. A STATUS byte with any other bits 7:6 changes nothing.
- R10: While `rst_n` is low, every control field is zero and `dev_sel_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbus_clk_i | input | 1 | Serial bus clock; bits are taken on its rising edge |
| cbus_dat_i | input | 1 | Serial bus data |
| cbus_mode_i | input | 1 | Mode line: low for address, high for data |
| clk_rate_o | output | 2 | Sample-clock ratio code |
| in_fmt_o | output | 3 | Serial audio format code |
| dc_filt_en_o | output | 1 | DC-removal filter enable |
| vol_code_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Playback mute |
| adc_en_o | output | 1 | ADC power enable |
| dac_en_o | output | 1 | DAC power enable |
| dev_sel_o | output | 1 | Last address byte matched this device |

## Verification
A field changes on the fourth system clock edge after the rising bus clock edge that carries the eighth bit: two synchroniser stages, one edge-detect and byte-complete register, and the field register. A mode change is seen three edges after it is driven. The bench holds every bus level for four system clocks and waits eight clocks after each byte before it samples, always on the falling system clock edge. Every check therefore lands after the result is due and before the next stimulus. For the partial-byte and ignored-byte cases, the bench reads the fields inside that same quiet window to show that they kept their earlier values.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int VOL_W     = 6;
  localparam int DEEMPH_W  = 2;
  localparam int RATE_W    = 2;
  localparam int FMT_W     = 3;
  localparam int DEV_W     = 6;

  typedef enum logic [1:0] {
    SET_NONE   = 2'd0,
    SET_DATA   = 2'd1,
    SET_STATUS = 2'd2
  } set_e;

  typedef struct packed {
    logic [RATE_W-1:0]   rate;
    logic [FMT_W-1:0]    fmt;
    logic                dc;
    logic [VOL_W-1:0]    vol;
    logic [DEEMPH_W-1:0] deemph;
    logic                mute;
    logic                adc_on;
    logic                dac_on;
  } ctl_regs_t;

  localparam int REGS_W = $bits(ctl_regs_t);

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;

    always_comb begin
      chain_n = {chain_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_n;
      end
    end

    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ctl3w_framer.sv
module ctl3w_framer
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              smode_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_addr_o
);

  logic              clk_q, mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, sh_shift;
  logic              vld_q, vld_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              addr_q, addr_n;
  logic              rise, mode_chg, last_bit;

  always_comb begin
    rise     = sclk_i & ~clk_q;
    mode_chg = smode_i ^ mode_q;
    sh_shift = {sdat_i, sh_q[BYTE_W-1:1]};
    last_bit = (cnt_q == CNT_W'(BYTE_W - 1));

    cnt_n  = cnt_q;
    sh_n   = sh_q;
    vld_n  = 1'b0;
    byte_n = byte_q;
    addr_n = addr_q;

    if (mode_chg) begin
      cnt_n = '0;
      sh_n  = '0;
    end else if (rise) begin
      sh_n = sh_shift;
      if (last_bit) begin
        cnt_n  = '0;
        vld_n  = 1'b1;
        byte_n = sh_shift;
        addr_n = ~smode_i;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
      addr_q <= 1'b0;
    end else begin
      clk_q  <= sclk_i;
      mode_q <= smode_i;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      vld_q  <= vld_n;
      byte_q <= byte_n;
      addr_q <= addr_n;
    end
  end

  assign byte_vld_o  = vld_q;
  assign byte_o      = byte_q;
  assign byte_addr_o = addr_q;

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_addr_i,
  output ctl_regs_t         regs_o,
  output logic              dev_sel_o
);

  ctl_regs_t regs_q, regs_n;
  logic      sel_q, sel_n;
  set_e      set_q, set_n;
  logic      addr_we, data_we;
  logic      ld_vol, ld_dm, ld_pwr, ld_stat;
  logic [1:0] sub;

  always_comb begin
    addr_we = byte_vld_i & byte_addr_i;
    data_we = byte_vld_i & ~byte_addr_i & sel_q;
    sub     = byte_i[BYTE_W-1 -: 2];

    ld_vol  = data_we & (set_q == SET_DATA)   & (sub == 2'b00);
    ld_dm   = data_we & (set_q == SET_DATA)   & (sub == 2'b10);
    ld_pwr  = data_we & (set_q == SET_DATA)   & (sub == 2'b11);
    ld_stat = data_we & (set_q == SET_STATUS) & (sub == 2'b00);

    sel_n = sel_q;
    set_n = set_q;
    if (addr_we) begin
      if (byte_i[BYTE_W-1:2] == DEV_ADDR) begin
        sel_n = 1'b1;
        unique case (byte_i[1:0])
          2'b00:   set_n = SET_DATA;
          2'b10:   set_n = SET_STATUS;
          default: set_n = SET_NONE;
        endcase
      end else begin
        sel_n = 1'b0;
        set_n = SET_NONE;
      end
    end

    regs_n = regs_q;
    if (ld_vol) begin
      regs_n.vol = byte_i[VOL_W-1:0];
    end
    if (ld_dm) begin
      regs_n.deemph = byte_i[4:3];
      regs_n.mute   = byte_i[2];
    end
    if (ld_pwr) begin
      regs_n.adc_on = byte_i[1];
      regs_n.dac_on = byte_i[0];
    end
    if (ld_stat) begin
      regs_n.rate = byte_i[5:4];
      regs_n.fmt  = byte_i[3:1];
      regs_n.dc   = byte_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      sel_q  <= 1'b0;
      set_q  <= SET_NONE;
    end else begin
      regs_q <= regs_n;
      sel_q  <= sel_n;
      set_q  <= set_n;
    end
  end

  assign regs_o    = regs_q;
  assign dev_sel_o = sel_q;

endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [DEV_W-1:0] DEV_ADDR    = 6'b000101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cbus_clk_i,
  input  logic                cbus_dat_i,
  input  logic                cbus_mode_i,
  output logic [RATE_W-1:0]   clk_rate_o,
  output logic [FMT_W-1:0]    in_fmt_o,
  output logic                dc_filt_en_o,
  output logic [VOL_W-1:0]    vol_code_o,
  output logic [DEEMPH_W-1:0] deemph_o,
  output logic                mute_o,
  output logic                adc_en_o,
  output logic                dac_en_o,
  output logic                dev_sel_o
);

  localparam int LINES = 3;

  logic [LINES-1:0]  w_sync;
  logic              w_byte_vld;
  logic [BYTE_W-1:0] w_byte;
  logic              w_byte_addr;
  ctl_regs_t         w_regs;

  ctl3w_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cbus_mode_i, cbus_dat_i, cbus_clk_i}),
    .q_o   (w_sync)
  );

  ctl3w_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (w_sync[0]),
    .sdat_i      (w_sync[1]),
    .smode_i     (w_sync[2]),
    .byte_vld_o  (w_byte_vld),
    .byte_o      (w_byte),
    .byte_addr_o (w_byte_addr)
  );

  ctl3w_regs #(
    .DEV_ADDR (DEV_ADDR)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld_i  (w_byte_vld),
    .byte_i      (w_byte),
    .byte_addr_i (w_byte_addr),
    .regs_o      (w_regs),
    .dev_sel_o   (dev_sel_o)
  );

  assign clk_rate_o   = w_regs.rate;
  assign in_fmt_o     = w_regs.fmt;
  assign dc_filt_en_o = w_regs.dc;
  assign vol_code_o   = w_regs.vol;
  assign deemph_o     = w_regs.deemph;
  assign mute_o       = w_regs.mute;
  assign adc_en_o     = w_regs.adc_on;
  assign dac_en_o     = w_regs.dac_on;

endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              byte_addr,
  input logic              dev_sel,
  input logic [REGS_W-1:0] regs
);

  AST_ONE_CYCLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R1

  AST_ADDR_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_addr) |=> $stable(regs)); // R2

  AST_DESEL_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_addr && !dev_sel) |=> $stable(regs)); // R3

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && byte_addr) |=> $stable(dev_sel)); // R4

  AST_NO_PARTIAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(regs)); // R5

endmodule

bind ctl3w_rx ctl3w_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_vld  (w_byte_vld),
  .byte_addr (w_byte_addr),
  .dev_sel   (dev_sel_o),
  .regs      (w_regs)
);

// File: tb/ctl3w_rx_tb.sv
module ctl3w_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cbus_clk, cbus_dat, cbus_mode;
  logic [1:0] clk_rate, deemph;
  logic [2:0] in_fmt;
  logic [5:0] vol;
  logic       dc_en, mute, adc_en, dac_en, dev_sel;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ctl3w_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cbus_clk_i   (cbus_clk),
    .cbus_dat_i   (cbus_dat),
    .cbus_mode_i  (cbus_mode),
    .clk_rate_o   (clk_rate),
    .in_fmt_o     (in_fmt),
    .dc_filt_en_o (dc_en),
    .vol_code_o   (vol),
    .deemph_o     (deemph),
    .mute_o       (mute),
    .adc_en_o     (adc_en),
    .dac_en_o     (dac_en),
    .dev_sel_o    (dev_sel)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic mode, input logic [7:0] b, input int nbits);
    cbus_mode = mode;
    wait_cyc(6);
    for (int i = 0; i < nbits; i++) begin
      cbus_dat = b[i];
      wait_cyc(4);
      cbus_clk = 1'b1;
      wait_cyc(4);
      cbus_clk = 1'b0;
    end
    wait_cyc(8);
  endtask

  task automatic send_addr(input logic [7:0] b);
    send_bits(1'b0, b, 8);
  endtask

  task automatic send_data(input logic [7:0] b);
    send_bits(1'b1, b, 8);
  endtask

  task automatic t_reset;
    chk("R10 vol", vol, 0);
    chk("R10 deemph/mute", {deemph, mute}, 0);
    chk("R10 power", {adc_en, dac_en}, 0);
    chk("R10 status", {clk_rate, in_fmt, dc_en}, 0);
    chk("R10 dev_sel", dev_sel, 0);
  endtask

  task automatic t_volume;
    send_addr(8'h14);
    chk("R2 dev_sel on match", dev_sel, 1);
    chk("R2 address byte leaves vol", vol, 0);
    send_data(8'h2A);
    chk("R1 R6 vol lsb-first", vol, 'h2A);
  endtask

  task automatic t_multibyte;
    send_data(8'h8C);
    chk("R7 deemph", deemph, 1);
    chk("R7 mute", mute, 1);
    send_data(8'hC2);
    chk("R8 power adc/dac", {adc_en, dac_en}, 2'b10);
    send_data(8'h55);
    chk("R7 unused sub keeps vol", vol, 'h2A);
    chk("R4 R7 unused sub keeps others", {deemph, mute, adc_en, dac_en}, 5'b01110);
  endtask

  task automatic t_status;
    send_addr(8'h16);
    send_data(8'h2B);
    chk("R9 clk rate", clk_rate, 2);
    chk("R9 format", in_fmt, 5);
    chk("R9 dc filter", dc_en, 1);
    chk("R9 status set leaves vol", vol, 'h2A);
    send_data(8'h6B);
    chk("R9 nonzero top bits ignored", {clk_rate, in_fmt, dc_en}, 6'b101011);
  endtask

  task automatic t_deselect;
    send_addr(8'h18);
    chk("R3 dev_sel off", dev_sel, 0);
    send_data(8'h11);
    chk("R3 vol ignored", vol, 'h2A);
    send_data(8'hC1);
    chk("R3 power ignored", {adc_en, dac_en}, 2'b10);
    send_addr(8'h15);
    chk("R2 unused type still matches", dev_sel, 1);
    send_data(8'h07);
    chk("R2 unused type drops data", vol, 'h2A);
  endtask

  task automatic t_partial;
    send_addr(8'h14);
    send_bits(1'b1, 8'h33, 7);
    chk("R5 partial byte no write", vol, 'h2A);
    cbus_mode = 1'b0;
    wait_cyc(6);
    send_data(8'h09);
    chk("R5 count restarts after mode change", vol, 'h09);
    send_data(8'hC1);
    chk("R4 set held across bytes", {adc_en, dac_en}, 2'b01);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    wait_cyc(2);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    rst_n     = 1'b0;
    cbus_clk  = 1'b0;
    cbus_dat  = 1'b0;
    cbus_mode = 1'b0;
    wait_cyc(4);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(4);
    t_volume;
    t_multibyte;
    t_status;
    t_deselect;
    t_partial;
    t_reset_again;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        wait_cyc(100000);
        n_vec++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule